// File: doc/BRIEF.md
# T1 Framer Interrupt Status Controller

This block gathers single-cycle event pulses from the transmit and receive sides of a T1 framer and latches them in a status register that a processor reads through a small register port. A mask register selects which latched bits may reach the active-low interrupt line and the summary bit in the global status register. A visibility bit decides whether masked events are latched at all. Reading the status register hands the processor the latched bits and clears them in the same access.

Two of the events are generated here from a transmit frame counter. The counter advances on a frame strobe, and the multiframe length and the signalling refill period follow the selected frame format. A transmit underrun places the transmitter and its FIFO in a held reset state, and only a read of the status register releases it.

Top module: `t1_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the mask register reads 0x1F (all events masked), the control register reads 0x00, the summary bit is 0, `irq_n` is 1, `tx_hold` is 0 and `frame_num` is 1.
- R2: Status bit positions are: 0 multiframe begin, 1 signalling registers empty, 2 all sent, 3 receive overflow, 4 transmit underrun. An unmasked event sets its bit at the next clock edge, and `irq_n` goes low in the cycle after the event.
- R3: With control bit 0 (visibility) at 0, an event whose mask bit is 1 leaves its status bit clear. With visibility at 1, the same event sets its status bit.
- R4: A latched bit whose mask bit is 1 neither pulls `irq_n` low nor sets the summary bit (address 3, bit 0).
- R5: A read at address 0 returns the latched bits in the same cycle and clears them at the clock edge that ends the read. An event that arrives in that same cycle stays set after the read.
- R6: Format codes are 2'b00 for F12, 2'b01 for F72 and 2'b10 for ESF. Multiframe lengths are 12, 72 and 24 frames. The multiframe-begin event fires on the frame strobe that starts frame 1, and `frame_num` shows the number of the next frame to start.
- R7: The signalling-empty event fires every 12 frames in F12 and F72 and every 24 frames in ESF, on the frame strobe that starts frame 1 of that period. In F12 and ESF it therefore coincides with multiframe begin.
- R8: A change on `fmt_sel` returns the frame counters to frame 1 at the next clock edge. A frame strobe in that cycle is ignored.
- R9: A transmit underrun pulse raises `tx_hold` at the next edge. `tx_hold` stays high until the clock edge that ends a status register read. A read of any other register leaves it high.
- R10: The all-sent event is raised only when `last_bit_out` and `txfifo_empty` are both high in the same cycle.
- R11: A write to the mask register (address 1) takes effect at the next edge. Clearing the mask bit of a bit that is already latched pulls `irq_n` low in the following cycle.
- R12: The summary bit at address 3, bit 0, is 1 exactly when `irq_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Frame format: 00 F12, 01 F72, 10 ESF |
| frame_tick | input | 1 | Strobe at the start of each transmitted frame |
| rx_ovf_ev | input | 1 | Receive FIFO overflow pulse |
| last_bit_out | input | 1 | Final bit of the current frame has left the transmitter |
| txfifo_empty | input | 1 | Transmit FIFO holds no data |
| tx_underrun_ev | input | 1 | Transmit underrun pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 mask, 2 control, 3 global status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq_n | output | 1 | Interrupt request, active low |
| sum_flag | output | 1 | Summary of unmasked latched status |
| tx_hold | output | 1 | Holds the transmitter and its FIFO in reset |
| frame_num | output | 7 | Number of the next transmit frame to start |

## Verification
The hardest case to reach is a status read that collides with a fresh event in the same cycle, because the clear and the set land on the same edge. The bench drives the read strobe and an event pulse together and then reads a second time to show the bit survived. The long F72 cadence is a second hard case: multiframe begin occurs only once every 72 strobes, with signalling-empty pulses between. It is reached by stepping the frame strobe through more than a full multiframe and reading status after each strobe against a frame model kept in the bench. A format switch in the middle of a count shows the restart to frame 1.

// File: rtl/tic_pkg.sv
package tic_pkg;

   typedef enum logic [1:0] {
      FMT_F12 = 2'b00,
      FMT_F72 = 2'b01,
      FMT_ESF = 2'b10
   } fmt_e;

   localparam int EV_MFB  = 0;
   localparam int EV_CSE  = 1;
   localparam int EV_ALLS = 2;
   localparam int EV_RDO  = 3;
   localparam int EV_XDU  = 4;
   localparam int NUM_EV  = 5;

   localparam logic [1:0] ADDR_STAT = 2'd0;
   localparam logic [1:0] ADDR_MASK = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;
   localparam logic [1:0] ADDR_GSUM = 2'd3;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tic_frame_ctr.sv
module tic_frame_ctr #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          adv,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] cnt,
   output logic          at_first
);

   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= ONE;
      end else if (restart) begin
         cnt <= ONE;
      end else if (adv) begin
         cnt <= (cnt >= limit) ? ONE : cnt + ONE;
      end
   end

   assign at_first = (cnt == ONE);

endmodule

// File: rtl/tic_stat_reg.sv
module tic_stat_reg #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] mask,
   input  logic         vis,
   input  logic         rd_clr,
   output logic [N-1:0] stat
);

   logic [N-1:0] take;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign take[i] = ev[i] & (vis | ~mask[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat <= (rd_clr ? '0 : stat) | take;
      end
   end

endmodule

// File: rtl/tic_txlock.sv
module tic_txlock (
   input  logic clk,
   input  logic rst_n,
   input  logic underrun,
   input  logic release_rd,
   output logic hold
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= 1'b0;
      end else if (underrun) begin
         hold <= 1'b1;
      end else if (release_rd) begin
         hold <= 1'b0;
      end
   end

endmodule

// File: rtl/t1_irq_ctrl.sv
module t1_irq_ctrl
   import tic_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 2,
   parameter int LEN_F12 = 12,
   parameter int LEN_F72 = 72,
   parameter int LEN_ESF = 24,
   parameter int SIG_F12 = 12,
   parameter int SIG_F72 = 12,
   parameter int SIG_ESF = 24,
   localparam int MAXLEN = max3(LEN_F12, LEN_F72, LEN_ESF),
   localparam int CW     = $clog2(MAXLEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    fmt_sel,
   input  logic          frame_tick,
   input  logic          rx_ovf_ev,
   input  logic          last_bit_out,
   input  logic          txfifo_empty,
   input  logic          tx_underrun_ev,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          irq_n,
   output logic          sum_flag,
   output logic          tx_hold,
   output logic [CW-1:0] frame_num
);

   localparam int NEV = NUM_EV;

   if (NEV > DW) begin : g_chk_dw
      $error("data width too small for the status register");
   end
   if (AW < 2) begin : g_chk_aw
      $error("address width must cover four registers");
   end
   if (SIG_F12 > LEN_F12 || SIG_ESF > LEN_ESF) begin : g_chk_sig
      $error("signalling period longer than multiframe");
   end

   logic [1:0]     fmt_q;
   logic           fmt_chg;
   logic [CW-1:0]  mf_len;
   logic [CW-1:0]  sig_len;
   logic [CW-1:0]  sig_num;
   logic           mf_first;
   logic           sig_first;
   logic           adv;
   logic [NEV-1:0] ev;
   logic [NEV-1:0] mask;
   logic [NEV-1:0] stat;
   logic           vis;
   logic           stat_rd;
   logic           mask_wr;
   logic           ctrl_wr;
   logic           unused_wdata;

   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fmt_q <= FMT_F12;
      else        fmt_q <= fmt_sel;
   end

   assign fmt_chg = (fmt_sel != fmt_q);
   assign adv     = frame_tick & ~fmt_chg;

   always_comb begin
      case (fmt_sel)
         FMT_F72: begin mf_len = CW'(LEN_F72); sig_len = CW'(SIG_F72); end
         FMT_ESF: begin mf_len = CW'(LEN_ESF); sig_len = CW'(SIG_ESF); end
         default: begin mf_len = CW'(LEN_F12); sig_len = CW'(SIG_F12); end
      endcase
   end

   tic_frame_ctr #(.CW(CW)) u_mf_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (fmt_chg),
      .adv      (adv),
      .limit    (mf_len),
      .cnt      (frame_num),
      .at_first (mf_first)
   );

   tic_frame_ctr #(.CW(CW)) u_sig_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (fmt_chg),
      .adv      (adv),
      .limit    (sig_len),
      .cnt      (sig_num),
      .at_first (sig_first)
   );

   always_comb begin
      ev          = '0;
      ev[EV_MFB]  = adv & mf_first;
      ev[EV_CSE]  = adv & sig_first;
      ev[EV_ALLS] = last_bit_out & txfifo_empty;
      ev[EV_RDO]  = rx_ovf_ev;
      ev[EV_XDU]  = tx_underrun_ev;
   end

   assign stat_rd = reg_rd  & (reg_addr == AW'(ADDR_STAT));
   assign mask_wr = reg_wr  & (reg_addr == AW'(ADDR_MASK));
   assign ctrl_wr = reg_wr  & (reg_addr == AW'(ADDR_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask <= '1;
         vis  <= 1'b0;
      end else begin
         if (mask_wr) mask <= reg_wdata[NEV-1:0];
         if (ctrl_wr) vis  <= reg_wdata[0];
      end
   end

   tic_stat_reg #(.N(NEV)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .mask   (mask),
      .vis    (vis),
      .rd_clr (stat_rd),
      .stat   (stat)
   );

   tic_txlock u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .underrun   (tx_underrun_ev),
      .release_rd (stat_rd),
      .hold       (tx_hold)
   );

   assign sum_flag = |(stat & ~mask);
   assign irq_n    = ~sum_flag;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(ADDR_STAT): reg_rdata[NEV-1:0] = stat;
         AW'(ADDR_MASK): reg_rdata[NEV-1:0] = mask;
         AW'(ADDR_CTRL): reg_rdata[0]       = vis;
         AW'(ADDR_GSUM): reg_rdata[0]       = sum_flag;
         default:        reg_rdata          = '0;
      endcase
   end

endmodule

// File: rtl/t1_irq_ctrl_chk.sv
module t1_irq_ctrl_chk #(
   parameter int NEV = 5,
   parameter int CW  = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_wr,
   input logic           stat_rd,
   input logic           mask_wr,
   input logic [NEV-1:0] ev,
   input logic [NEV-1:0] mask,
   input logic [NEV-1:0] stat,
   input logic           vis,
   input logic           irq_n,
   input logic           tx_hold,
   input logic           tx_underrun_ev,
   input logic [1:0]     fmt_sel,
   input logic [1:0]     fmt_q,
   input logic [CW-1:0]  frame_num,
   input logic [CW-1:0]  mf_len
);

   AST_IRQ_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(ev & ~mask)) && !mask_wr) |=> !irq_n); // R2

   AST_MASKED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!vis && !reg_wr && ((stat & mask) == '0)) |=> ((stat & mask) == '0)); // R3

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && (ev == '0)) |=> (stat == '0)); // R5

   AST_EVENT_SURVIVES_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && ((ev & ~mask) != '0)) |=> (stat != '0)); // R5

   AST_FRAME_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel == fmt_q) |-> (frame_num >= 1 && frame_num <= mf_len)); // R6

   AST_FMT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel != fmt_q) |=> (frame_num == 1)); // R8

   AST_UNDERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun_ev |=> tx_hold); // R9

   AST_HOLD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_hold && !stat_rd) |=> tx_hold); // R9

endmodule

bind t1_irq_ctrl t1_irq_ctrl_chk #(.NEV(NEV), .CW(CW)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .reg_wr         (reg_wr),
   .stat_rd        (stat_rd),
   .mask_wr        (mask_wr),
   .ev             (ev),
   .mask           (mask),
   .stat           (stat),
   .vis            (vis),
   .irq_n          (irq_n),
   .tx_hold        (tx_hold),
   .tx_underrun_ev (tx_underrun_ev),
   .fmt_sel        (fmt_sel),
   .fmt_q          (fmt_q),
   .frame_num      (frame_num),
   .mf_len         (mf_len)
);

// File: tb/t1_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module t1_irq_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] fmt_sel = 2'b00;
   logic       frame_tick = 1'b0;
   logic       rx_ovf_ev = 1'b0;
   logic       last_bit_out = 1'b0;
   logic       txfifo_empty = 1'b0;
   logic       tx_underrun_ev = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_n;
   logic       sum_flag;
   logic       tx_hold;
   logic [6:0] frame_num;

   t1_irq_ctrl dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .fmt_sel        (fmt_sel),
      .frame_tick     (frame_tick),
      .rx_ovf_ev      (rx_ovf_ev),
      .last_bit_out   (last_bit_out),
      .txfifo_empty   (txfifo_empty),
      .tx_underrun_ev (tx_underrun_ev),
      .reg_wr         (reg_wr),
      .reg_rd         (reg_rd),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .irq_n          (irq_n),
      .sum_flag       (sum_flag),
      .tx_hold        (tx_hold),
      .frame_num      (frame_num)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int         q_due[$];
   int         q_kind[$];
   logic [7:0] q_exp[$];
   string      q_req[$];

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: pops the expected items due in this cycle and compares them.
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         int         k;
         logic [7:0] e;
         logic [7:0] a;
         string      r;
         k = q_kind.pop_front();
         e = q_exp.pop_front();
         r = q_req.pop_front();
         void'(q_due.pop_front());
         case (k)
            0:       a = reg_rdata;
            1:       a = {7'd0, irq_n};
            2:       a = {7'd0, tx_hold};
            3:       a = {1'b0, frame_num};
            default: a = {7'd0, sum_flag};
         endcase
         n_checks++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h cycle=%0d", r, k, a, e, cyc);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic expect_now(input int kind, input logic [7:0] exp, input string req);
      q_due.push_back(cyc);
      q_kind.push_back(kind);
      q_exp.push_back(exp);
      q_req.push_back(req);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      reg_rd = 1'b1; reg_addr = a;
      expect_now(0, exp, req);
      step();
      reg_rd = 1'b0;
   endtask

   task automatic pulse_ovf();
      rx_ovf_ev = 1'b1;
      step();
      rx_ovf_ev = 1'b0;
   endtask

   // Frame model: fr/sg are the next frame within multiframe / signalling period.
   int fr = 1;
   int sg = 1;

   task automatic run_frames(input int n, input int mlen, input int slen, input string req);
      for (int i = 0; i < n; i++) begin
         logic [7:0] e;
         e = ((fr == 1) ? 8'h01 : 8'h00) | ((sg == 1) ? 8'h02 : 8'h00);
         frame_tick = 1'b1;
         step();
         frame_tick = 1'b0;
         fr = (fr >= mlen) ? 1 : fr + 1;
         sg = (sg >= slen) ? 1 : sg + 1;
         expect_now(3, 8'(fr), "R6");
         rd(2'd0, e, req);
      end
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      expect_now(1, 8'h01, "R1");
      expect_now(2, 8'h00, "R1");
      expect_now(3, 8'h01, "R1");
      expect_now(4, 8'h00, "R1");
      rd(2'd1, 8'h1F, "R1");
      rd(2'd0, 8'h00, "R1");
      rd(2'd2, 8'h00, "R1");
      rd(2'd3, 8'h00, "R1");

      // R2 unmasked event latches and raises the interrupt
      wr(2'd1, 8'h00);
      pulse_ovf();
      expect_now(1, 8'h00, "R2");
      expect_now(4, 8'h01, "R12");
      rd(2'd3, 8'h01, "R12");
      rd(2'd0, 8'h08, "R2");
      expect_now(1, 8'h01, "R5");
      rd(2'd0, 8'h00, "R5");

      // R10 all-sent needs both conditions
      last_bit_out = 1'b1; txfifo_empty = 1'b0;
      step();
      last_bit_out = 1'b0; txfifo_empty = 1'b1;
      step();
      txfifo_empty = 1'b0;
      rd(2'd0, 8'h00, "R10");
      last_bit_out = 1'b1; txfifo_empty = 1'b1;
      step();
      last_bit_out = 1'b0; txfifo_empty = 1'b0;
      rd(2'd0, 8'h04, "R10");

      // R3 masked event with visibility off does not latch
      wr(2'd1, 8'h1F);
      pulse_ovf();
      rd(2'd0, 8'h00, "R3");
      // visibility on: latches, R4 no interrupt and no summary
      wr(2'd2, 8'h01);
      rd(2'd2, 8'h01, "R3");
      pulse_ovf();
      expect_now(1, 8'h01, "R4");
      expect_now(4, 8'h00, "R4");
      rd(2'd3, 8'h00, "R4");
      // R11 unmask latched bit asserts the interrupt after the write edge
      reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h17;
      expect_now(1, 8'h01, "R11");
      step();
      reg_wr = 1'b0;
      expect_now(1, 8'h00, "R11");
      rd(2'd0, 8'h08, "R3");
      wr(2'd2, 8'h00);

      // R5 read colliding with a new event keeps the new event
      wr(2'd1, 8'h00);
      pulse_ovf();
      rx_ovf_ev = 1'b1; reg_rd = 1'b1; reg_addr = 2'd0;
      expect_now(0, 8'h08, "R5");
      step();
      rx_ovf_ev = 1'b0; reg_rd = 1'b0;
      expect_now(1, 8'h00, "R5");
      rd(2'd0, 8'h08, "R5");
      rd(2'd0, 8'h00, "R5");

      // R9 underrun hold until status read
      tx_underrun_ev = 1'b1;
      step();
      tx_underrun_ev = 1'b0;
      expect_now(2, 8'h01, "R9");
      repeat (4) step();
      expect_now(2, 8'h01, "R9");
      rd(2'd1, 8'h00, "R9");
      expect_now(2, 8'h01, "R9");
      rd(2'd0, 8'h10, "R9");
      expect_now(2, 8'h00, "R9");

      // R6 / R7 frame events per format
      fr = 1; sg = 1;
      run_frames(26, 12, 12, "R7");
      fmt_sel = 2'b01;
      frame_tick = 1'b1;
      step();
      frame_tick = 1'b0;
      fr = 1; sg = 1;
      expect_now(3, 8'h01, "R8");
      rd(2'd0, 8'h00, "R8");
      run_frames(80, 72, 12, "R6");
      fmt_sel = 2'b10;
      step();
      fr = 1; sg = 1;
      expect_now(3, 8'h01, "R8");
      run_frames(50, 24, 24, "R7");

      step();
      done = 1'b1;
   end

   initial begin
      int wd;
      wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired: actual=hung expected=done");
      end
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule